// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Blanking Controls

The block turns a four-bit binary-coded decimal digit into drive levels for the seven segments of a common-anode display. A segment lights when its output is low. Three active-low controls sit on top of the decoding. One forces the display dark. One lights every segment so that an operator can check the lamps. One marks the digit as a candidate for leading-zero suppression.

For multi-digit readouts the decoders are chained. Each decoder's zero-suppression output feeds the zero-suppression input of the next less significant digit. The most significant digit has its input tied low. Leading zeros then go dark, and the first non-zero digit breaks the chain.

The decode is combinational. A parameter can add an output register, whose reset release is synchronised inside the block.

Top module: `seg7_bcd_decoder`

## Requirements
- R1: With `blank_n`, `lamp_test_n` and `zero_blank_in_n` high, digits 0 to 9 give the usual glyphs, where a lit segment is a 0 bit. The bit order of `seg_n` is bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g. The lit sets are: 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg, 5 = acdfg, 6 = acdefg, 7 = abc, 8 = all seven, 9 = abcdfg.
- R2: Input codes 10 to 15 drive `seg_n` to 7'h7F (all dark) when blanking and lamp test are inactive.
- R3: `blank_n` low drives `seg_n` to 7'h7F whatever the digit, lamp test or zero-suppression input.
- R4: `lamp_test_n` low with `blank_n` high drives `seg_n` to 7'h00 for every digit and every zero-suppression input.
- R5: `zero_blank_in_n` low with digit 0 drives `seg_n` to 7'h7F, provided `blank_n` and `lamp_test_n` are high.
- R6: `zero_blank_out_n` is low exactly when `zero_blank_in_n` is low and the digit is 0. It does not depend on `blank_n` or `lamp_test_n`.
- R7: `zero_blank_in_n` low with a non-zero digit leaves the normal decode of R1 and R2 unchanged.
- R8: With `OUT_REG` = 1 (the default), outputs follow the inputs one clock later. While `rst_n` is low the outputs hold `seg_n` = 7'h7F and `zero_blank_out_n` = 1. The release of `rst_n` takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_in | input | 4 | BCD digit, bit 0 least significant |
| lamp_test_n | input | 1 | Active-low lamp test, lights all segments |
| blank_n | input | 1 | Active-low forced blanking |
| zero_blank_in_n | input | 1 | Active-low zero-suppression enable from the more significant digit |
| zero_blank_out_n | output | 1 | Active-low zero-suppression output toward the less significant digit |
| seg_n | output | 7 | Active-low segment drives, bit 0 = a through bit 6 = g |

## Verification
The three controls, together with a zero digit, can all be asserted in the same cycle. Their fixed precedence is the main point of interest: blanking over lamp test, lamp test over zero suppression, and zero suppression over decode. The bench sweeps all sixteen codes against all eight control combinations. The collisions therefore include lamp test on a suppressed zero and blanking during lamp test. Each output is judged against an expected value that is computed independently, by the priority order, from per-segment digit masks. The suppression output is checked separately, because it must not follow blanking or lamp test.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

  localparam int unsigned SEG_W = 7;
  localparam int unsigned BCD_W = 4;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [BCD_W-1:0] digit_t;

  localparam seg_t SEG_ALL_OFF = '1;
  localparam seg_t SEG_ALL_ON  = '0;

  // Lit-segment sets, active high, bit 0 = a ... bit 6 = g
  function automatic seg_t glyph_lit(input digit_t d);
    seg_t lit;
    case (d)
      4'd0:    lit = 7'b011_1111;
      4'd1:    lit = 7'b000_0110;
      4'd2:    lit = 7'b101_1011;
      4'd3:    lit = 7'b100_1111;
      4'd4:    lit = 7'b110_0110;
      4'd5:    lit = 7'b110_1101;
      4'd6:    lit = 7'b111_1101;
      4'd7:    lit = 7'b000_0111;
      4'd8:    lit = 7'b111_1111;
      4'd9:    lit = 7'b110_1111;
      default: lit = 7'b000_0000;
    endcase
    return lit;
  endfunction

endpackage

// File: rtl/seg7_glyph_rom.sv
module seg7_glyph_rom
  import seg7_pkg::*;
(
  input  digit_t digit,
  output seg_t   glyph_n,
  output logic   is_zero
);

  seg_t lit;

  always_comb begin
    lit     = glyph_lit(digit);
    glyph_n = ~lit;
    is_zero = (digit == '0);
  end

endmodule

// File: rtl/seg7_blank_ctl.sv
module seg7_blank_ctl
  import seg7_pkg::*;
(
  input  seg_t glyph_n,
  input  logic is_zero,
  input  logic lamp_test_n,
  input  logic blank_n,
  input  logic zero_blank_in_n,
  output seg_t seg_next_n,
  output logic zbo_next_n
);

  logic suppress;

  always_comb begin
    suppress    = !zero_blank_in_n && is_zero;
    zbo_next_n  = !suppress;
    if (!blank_n)          seg_next_n = SEG_ALL_OFF;
    else if (!lamp_test_n) seg_next_n = SEG_ALL_ON;
    else if (suppress)     seg_next_n = SEG_ALL_OFF;
    else                   seg_next_n = glyph_n;
  end

endmodule

// File: rtl/seg7_out_stage.sv
module seg7_out_stage
  import seg7_pkg::*;
#(
  parameter bit          OUT_REG   = 1'b1,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  seg_t seg_next_n,
  input  logic zbo_next_n,
  output seg_t seg_n,
  output logic zbo_n
);

  generate
    if (OUT_REG) begin : g_reg
      logic [SYNC_DEPTH-1:0] sync_q;
      logic                  rst_sync_n;
      seg_t                  seg_q;
      logic                  zbo_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_DEPTH-2:0], 1'b1};
      end

      assign rst_sync_n = sync_q[SYNC_DEPTH-1];

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
          seg_q <= SEG_ALL_OFF;
          zbo_q <= 1'b1;
        end else begin
          seg_q <= seg_next_n;
          zbo_q <= zbo_next_n;
        end
      end

      assign seg_n = seg_q;
      assign zbo_n = zbo_q;
    end else begin : g_comb
      assign seg_n = seg_next_n;
      assign zbo_n = zbo_next_n;
    end
  endgenerate

endmodule

// File: rtl/seg7_bcd_decoder.sv
module seg7_bcd_decoder
  import seg7_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bcd_in,
  input  logic       lamp_test_n,
  input  logic       blank_n,
  input  logic       zero_blank_in_n,
  output logic       zero_blank_out_n,
  output logic [6:0] seg_n
);

  localparam int unsigned SYNC_DEPTH = 2;

  seg_t glyph_n;
  logic is_zero;
  seg_t seg_next_n;
  logic zbo_next_n;

  seg7_glyph_rom u_rom (
    .digit   (bcd_in),
    .glyph_n (glyph_n),
    .is_zero (is_zero)
  );

  seg7_blank_ctl u_ctl (
    .glyph_n         (glyph_n),
    .is_zero         (is_zero),
    .lamp_test_n     (lamp_test_n),
    .blank_n         (blank_n),
    .zero_blank_in_n (zero_blank_in_n),
    .seg_next_n      (seg_next_n),
    .zbo_next_n      (zbo_next_n)
  );

  seg7_out_stage #(
    .OUT_REG    (OUT_REG),
    .SYNC_DEPTH (SYNC_DEPTH)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .seg_next_n (seg_next_n),
    .zbo_next_n (zbo_next_n),
    .seg_n      (seg_n),
    .zbo_n      (zero_blank_out_n)
  );

endmodule

// File: rtl/seg7_bcd_decoder_chk.sv
module seg7_bcd_decoder_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bcd_in,
  input logic       lamp_test_n,
  input logic       blank_n,
  input logic       zero_blank_in_n,
  input logic       zero_blank_out_n,
  input logic [6:0] seg_n
);

  // Cycles since reset release; outputs are trusted after 3 edges when registered
  logic [1:0] up_cnt;
  logic [3:0] d_bcd;
  logic       d_lt, d_bl, d_zb;
  logic [3:0] c_bcd;
  logic       c_lt, c_bl, c_zb, valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= '0;
      d_bcd  <= '0;
      d_lt   <= 1'b1;
      d_bl   <= 1'b1;
      d_zb   <= 1'b1;
    end else begin
      if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
      d_bcd <= bcd_in;
      d_lt  <= lamp_test_n;
      d_bl  <= blank_n;
      d_zb  <= zero_blank_in_n;
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      assign c_bcd = d_bcd;
      assign c_lt  = d_lt;
      assign c_bl  = d_bl;
      assign c_zb  = d_zb;
      assign valid = (up_cnt == 2'd3);
    end else begin : g_comb
      assign c_bcd = bcd_in;
      assign c_lt  = lamp_test_n;
      assign c_bl  = blank_n;
      assign c_zb  = zero_blank_in_n;
      assign valid = rst_n;
    end
  endgenerate

  a_r3_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !c_bl |-> seg_n == 7'h7F);

  a_r4_lamp_lights: assert property (@(posedge clk) disable iff (!rst_n)
    valid && c_bl && !c_lt |-> seg_n == 7'h00);

  a_r5_zero_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    valid && c_bl && c_lt && !c_zb && c_bcd == 4'd0 |-> seg_n == 7'h7F);

  a_r6_ripple_out: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> zero_blank_out_n == !(!c_zb && c_bcd == 4'd0));

  a_r2_invalid_dark: assert property (@(posedge clk) disable iff (!rst_n)
    valid && c_bl && c_lt && c_bcd > 4'd9 |-> seg_n == 7'h7F);

  a_r1_digit_one: assert property (@(posedge clk) disable iff (!rst_n)
    valid && c_bl && c_lt && c_bcd == 4'd1 |-> seg_n == 7'b111_1001);

  a_r7_nonzero_kept: assert property (@(posedge clk) disable iff (!rst_n)
    valid && c_bl && c_lt && !c_zb && c_bcd == 4'd8 |-> seg_n == 7'h00);

endmodule

bind seg7_bcd_decoder seg7_bcd_decoder_chk #(.OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_seg7_bcd_decoder.sv
module sim_seg7_bcd_decoder;

  logic       clk;
  logic       rst_n;
  logic [3:0] bcd_in;
  logic       lamp_test_n;
  logic       blank_n;
  logic       zero_blank_in_n;
  logic       zero_blank_out_n;
  logic [6:0] seg_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  seg7_bcd_decoder #(.OUT_REG(1'b1)) u0 (
    .clk              (clk),
    .rst_n            (rst_n),
    .bcd_in           (bcd_in),
    .lamp_test_n      (lamp_test_n),
    .blank_n          (blank_n),
    .zero_blank_in_n  (zero_blank_in_n),
    .zero_blank_out_n (zero_blank_out_n),
    .seg_n            (seg_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Digit sets per segment, bit k set when digit k lights the segment
  function automatic logic [6:0] exp_seg(input logic [3:0] d, input logic lt,
                                         input logic bl, input logic zb);
    logic [9:0] mask [7];
    logic [6:0] r;
    mask[0] = 10'h3ED; mask[1] = 10'h39F; mask[2] = 10'h3FB; mask[3] = 10'h36D;
    mask[4] = 10'h145; mask[5] = 10'h371; mask[6] = 10'h37C;
    if (!bl)                   r = 7'h7F;
    else if (!lt)              r = 7'h00;
    else if (!zb && d == 4'd0) r = 7'h7F;
    else if (d > 4'd9)         r = 7'h7F;
    else for (int s = 0; s < 7; s++) r[s] = !mask[s][d];
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] d, input logic lt, input logic bl, input logic zb);
    @(negedge clk);
    bcd_in = d; lamp_test_n = lt; blank_n = bl; zero_blank_in_n = zb;
  endtask

  initial begin
    rst_n = 1'b1;
    bcd_in = 4'd8; lamp_test_n = 1'b1; blank_n = 1'b1; zero_blank_in_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset seg", {1'b0, seg_n}, 8'h7F);
    check("R8 reset ripple", {7'b0, zero_blank_out_n}, 8'h01);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8 sync release holds", {1'b0, seg_n}, 8'h7F);
    repeat (3) @(posedge clk);
    #1;
    check("R8 after release", {1'b0, seg_n}, 8'h00);

    // R8 latency: change input, output unchanged until next edge
    apply(4'd1, 1'b1, 1'b1, 1'b1);
    #1;
    check("R8 no early change", {1'b0, seg_n}, 8'h00);
    @(posedge clk); #1;
    check("R8 one-cycle update", {1'b0, seg_n}, 8'h79);

    // Exhaustive sweep: all codes against all control combinations
    for (int i = 0; i < 128; i++) begin
      logic [3:0] d;
      logic lt, bl, zb;
      string tag;
      d  = i[3:0];
      lt = i[4]; bl = i[5]; zb = i[6];
      apply(d, lt, bl, zb);
      @(posedge clk); #1;
      if (!bl)                   tag = "R3 blank";
      else if (!lt)              tag = "R4 lamp test";
      else if (!zb && d == 4'd0) tag = "R5 zero suppress";
      else if (!zb)              tag = "R7 nonzero kept";
      else if (d > 4'd9)         tag = "R2 invalid code";
      else                       tag = "R1 glyph";
      check(tag, {1'b0, seg_n}, {1'b0, exp_seg(d, lt, bl, zb)});
      check("R6 ripple out", {7'b0, zero_blank_out_n},
            {7'b0, !(!zb && d == 4'd0)});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule